// File: doc/BRIEF.md
# Bypassing Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits, entirely in combinational logic. It is built as a carry-save array of full-adder cells. There are `WIDTH-1` adder rows, each with `WIDTH-1` cells. A ripple-carry row at the bottom resolves the carries that remain. Every cell carries an enable. A disabled cell blocks its inputs by AND gating, forwards the sum arriving from above, and emits no carry. This saves switching when operand bits are zero.

The `MODE` parameter picks which operand drives the enables, and the ports are the same for both choices. In column mode, multiplicand bit `a[i]` enables the diagonal of cells that adds `a[i]`. In row mode, multiplier bit `b[r]` enables adder row `r`. A row-mode cell also wakes when a carry is pending on its carry input. This keeps the product exact when a zero multiplier bit follows an active row. The block has no registers, so a surrounding datapath decides when the product is sampled.

Top module: `bam_bypass_mult`

## Requirements
- R1: For every operand pair, in both modes, `product` equals the unsigned product `a*b`, with `a` and `b` zero-extended to `2*WIDTH` bits.
- R2: When either operand is zero, `product` is zero.
- R3: In column mode (`MODE = BAM_COLUMN`), a cell whose multiplicand bit is 0 forwards the sum from the cell above and outputs carry 0. Such a cell never receives a nonzero carry.
- R4: In row mode (`MODE = BAM_ROW`), an adder row whose multiplier bit is 0 and which receives no carry produces no carries. Its sum bits are the previous row's sum bits moved down one weight.
- R5: In row mode, a row whose multiplier bit is 0 but which receives pending carries still absorbs them, so the product stays exact. Example at width 4: 1111 × 1011 = 165.
- R6: The bottom ripple row carries through the whole upper half of the product, so all-ones times all-ones is exact. Examples: 15 × 15 = 225 and 65535 × 65535 = 4294836225.
- R7: When one operand is 1, `product` equals the other operand, zero-extended.
- R8: The port list is identical in both modes, and for equal operands both modes give equal products. `WIDTH` below 2 is rejected at elaboration.
- R9: At width 4, column mode gives 1010 × 1111 = 150 with diagonals 0 and 2 bypassed. Row mode gives 1111 × 1001 = 135 with adder rows 1 and 2 idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Multiplicand; its bits drive the diagonal enables in column mode |
| b | input | WIDTH | Multiplier; its bits drive the row enables in row mode |
| product | output | 2*WIDTH | Unsigned product a*b |

## Verification
Two functions can meet in the same adder row: bypassing a row for a zero multiplier bit, and absorbing carries left by the active row above. Operands such as 1111 × 1011 provoke this. Row 1 generates carries, and row 2 has a zero selector bit. The product is judged against the arithmetic value computed in the bench. The exhaustive width-4 sweep and the random width-16 sweep run column and row instances side by side. Each result must match the expected product, and the two modes must agree with each other.

// File: rtl/bam_pkg.sv
package bam_pkg;

   // Which operand drives the per-cell bypass enables.
   typedef enum logic [0:0] {
      BAM_COLUMN = 1'b0,
      BAM_ROW    = 1'b1
   } bam_mode_e;

   // Smallest operand width the array supports.
   localparam int unsigned BAM_MIN_WIDTH = 2;

endpackage

// File: rtl/bam_pp_gen.sv
module bam_pp_gen #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0]       opa,
   input  logic [WIDTH-1:0]       opb,
   output logic [WIDTH*WIDTH-1:0] pp_flat
);
   // pp_flat[r*WIDTH + i] = opa[i] & opb[r], weight r+i
   for (genvar r = 0; r < WIDTH; r++) begin : g_pp_row
      assign pp_flat[r*WIDTH +: WIDTH] = opa & {WIDTH{opb[r]}};
   end
endmodule

// File: rtl/bam_fa_cell.sv
module bam_fa_cell
   import bam_pkg::*;
#(
   parameter bam_mode_e MODE = BAM_COLUMN
) (
   input  logic en,
   input  logic sum_up,
   input  logic pp_bit,
   input  logic carry_in,
   output logic sum_dn,
   output logic carry_out
);
   logic g_sum, g_pp, g_cin;
   logic fa_sum, fa_carry;

   // Input isolation: a disabled cell sees all-zero inputs.
   assign g_sum = sum_up   & en;
   assign g_pp  = pp_bit   & en;
   assign g_cin = carry_in & en;

   assign fa_sum   = g_sum ^ g_pp ^ g_cin;
   assign fa_carry = (g_sum & g_pp) | (g_sum & g_cin) | (g_pp & g_cin);

   // Bypass multiplexer.
   assign sum_dn    = en ? fa_sum   : sum_up;
   assign carry_out = en ? fa_carry : 1'b0;

   if (MODE == BAM_COLUMN) begin : g_col_chk
      // R3: the diagonal above a bypassed cell is also bypassed, so no carry arrives.
      always_comb begin
         if (!en) begin
            p_col_carry_idle_r3: assert (carry_in == 1'b0)
               else $error("column bypass cell received a carry");
         end
      end
   end
endmodule

// File: rtl/bam_cpa_row.sv
module bam_cpa_row #(
   parameter int unsigned BITS = 7
) (
   input  logic [BITS-1:0] x,
   input  logic [BITS-1:0] y,
   output logic [BITS-1:0] sum,
   output logic            cout
);
   logic [BITS:0] rip;

   assign rip[0] = 1'b0;
   for (genvar k = 0; k < BITS; k++) begin : g_rip
      assign sum[k]   = x[k] ^ y[k] ^ rip[k];
      assign rip[k+1] = (x[k] & y[k]) | (x[k] & rip[k]) | (y[k] & rip[k]);
   end
   assign cout = rip[BITS];

   // R6: the ripple row adds its two vectors exactly.
   always_comb begin
      p_cpa_sum_r6: assert ({cout, sum} == ({1'b0, x} + {1'b0, y}))
         else $error("ripple row sum mismatch");
   end
endmodule

// File: rtl/bam_bypass_mult.sv
module bam_bypass_mult
   import bam_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter bam_mode_e   MODE  = BAM_COLUMN
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [2*WIDTH-1:0] product
);
   localparam int unsigned ROWS  = WIDTH;
   localparam int unsigned CELLS = WIDTH - 1;
   localparam int unsigned PW    = 2 * WIDTH;

   // R8: elaboration-time parameter check.
   if (WIDTH < BAM_MIN_WIDTH) begin : g_bad_width
      $error("bam_bypass_mult: WIDTH must be at least 2");
   end

   logic [WIDTH*WIDTH-1:0] pp_flat;

   bam_pp_gen #(.WIDTH(WIDTH)) u_pp (
      .opa     (a),
      .opb     (b),
      .pp_flat (pp_flat)
   );

   // Row r holds sums of weight r+i and carries of weight r+i+1.
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [WIDTH-1:0] row_s;
      logic [CELLS-1:0] row_c;

      if (r == 0) begin : g_top
         assign row_s = pp_flat[0 +: WIDTH];
         assign row_c = '0;
      end else begin : g_add
         for (genvar i = 0; i < CELLS; i++) begin : g_cell
            logic cell_en;
            if (MODE == BAM_COLUMN) begin : g_en_col
               assign cell_en = a[i];
            end else begin : g_en_row
               // Carry-aware row enable: wake for a pending carry.
               assign cell_en = b[r] | g_row[r-1].row_c[i];
            end

            bam_fa_cell #(.MODE(MODE)) u_cell (
               .en        (cell_en),
               .sum_up    (g_row[r-1].row_s[i+1]),
               .pp_bit    (pp_flat[r*WIDTH + i]),
               .carry_in  (g_row[r-1].row_c[i]),
               .sum_dn    (row_s[i]),
               .carry_out (row_c[i])
            );
         end
         assign row_s[WIDTH-1] = pp_flat[r*WIDTH + WIDTH - 1];

         if (MODE == BAM_ROW) begin : g_row_chk
            // R4: idle row passes sums down and emits no carries.
            always_comb begin
               if (!b[r] && (g_row[r-1].row_c == '0)) begin
                  p_row_idle_r4: assert ((row_c == '0) &&
                                         (row_s[WIDTH-2:0] == g_row[r-1].row_s[WIDTH-1:1]))
                     else $error("idle row disturbed sums or carries");
               end
            end
         end
      end

      assign product[r] = row_s[0];
   end

   bam_cpa_row #(.BITS(CELLS)) u_cpa (
      .x    (g_row[ROWS-1].row_s[WIDTH-1:1]),
      .y    (g_row[ROWS-1].row_c),
      .sum  (product[PW-2:WIDTH]),
      .cout (product[PW-1])
   );

   // R1 / R2 / R7: port-level arithmetic checks.
   always_comb begin
      p_product_exact_r1: assert (product == ({{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b}))
         else $error("product mismatch");
      if ((a == '0) || (b == '0)) begin
         p_zero_operand_r2: assert (product == '0)
            else $error("zero operand gave nonzero product");
      end
      if (a == WIDTH'(1)) begin
         p_identity_r7: assert (product == {{WIDTH{1'b0}}, b})
            else $error("identity operand failed");
      end
   end
endmodule

// File: tb/bam_bypass_mult_test.sv
`timescale 1ns/1ps
module bam_bypass_mult_test;
   import bam_pkg::*;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [3:0]  a4,  b4;
   logic [15:0] a16, b16;
   logic [7:0]  pc4, pr4;
   logic [31:0] pc16, pr16;

   bam_bypass_mult #(.WIDTH(4),  .MODE(BAM_COLUMN)) uut     (.a(a4),  .b(b4),  .product(pc4));
   bam_bypass_mult #(.WIDTH(4),  .MODE(BAM_ROW))    uut_r4  (.a(a4),  .b(b4),  .product(pr4));
   bam_bypass_mult #(.WIDTH(16), .MODE(BAM_COLUMN)) uut_c16 (.a(a16), .b(b16), .product(pc16));
   bam_bypass_mult #(.WIDTH(16), .MODE(BAM_ROW))    uut_r16 (.a(a16), .b(b16), .product(pr16));

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic drive4(input logic [3:0] x, input logic [3:0] y);
      @(posedge clk);
      a4 = x; b4 = y;
      @(negedge clk);
   endtask

   task automatic drive16(input logic [15:0] x, input logic [15:0] y);
      @(posedge clk);
      a16 = x; b16 = y;
      @(negedge clk);
   endtask

   function automatic logic [31:0] mul(input logic [15:0] x, input logic [15:0] y);
      return {16'd0, x} * {16'd0, y};
   endfunction

   task automatic t_reset_state();
      drive4(4'd0, 4'd0);
      drive16(16'd0, 16'd0);
      check("R2 col4 idle", {24'd0, pc4}, 32'd0);
      check("R2 row4 idle", {24'd0, pr4}, 32'd0);
      check("R2 col16 idle", pc16, 32'd0);
      check("R2 row16 idle", pr16, 32'd0);
   endtask

   task automatic t_exhaustive4();
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            drive4(4'(x), 4'(y));
            check("R1 col4", {24'd0, pc4}, 32'(x * y));
            check("R1 row4", {24'd0, pr4}, 32'(x * y));
         end
      end
   endtask

   task automatic t_random16();
      for (int n = 0; n < 400; n++) begin
         logic [15:0] x, y;
         x = 16'($urandom());
         y = 16'($urandom());
         if (n % 4 == 1) x = x & 16'h5A5A;   // sparse multiplicand: many bypassed diagonals
         if (n % 4 == 2) y = y & 16'h0F0F;   // sparse multiplier: idle and carry-absorbing rows
         drive16(x, y);
         check("R1 col16", pc16, mul(x, y));
         check("R1 row16", pr16, mul(x, y));
         check("R8 modes agree", pc16, pr16);
      end
   endtask

   task automatic t_doc_patterns();
      drive4(4'b1010, 4'b1111);
      check("R9 R3 col 1010x1111", {24'd0, pc4}, 32'd150);
      drive4(4'b1111, 4'b1001);
      check("R9 R4 row 1111x1001", {24'd0, pr4}, 32'd135);
   endtask

   task automatic t_pending_carry();
      drive4(4'b1111, 4'b1011);
      check("R5 row 1111x1011", {24'd0, pr4}, 32'd165);
      drive4(4'b0111, 4'b0011);
      check("R5 row 0111x0011", {24'd0, pr4}, 32'd21);
      drive16(16'hFFFF, 16'h8003);
      check("R5 row16 carry into zero rows", pr16, mul(16'hFFFF, 16'h8003));
   endtask

   task automatic t_full_carry();
      drive4(4'hF, 4'hF);
      check("R6 col4 max", {24'd0, pc4}, 32'd225);
      check("R6 row4 max", {24'd0, pr4}, 32'd225);
      drive16(16'hFFFF, 16'hFFFF);
      check("R6 col16 max", pc16, 32'd4294836225);
      check("R6 row16 max", pr16, 32'd4294836225);
   endtask

   task automatic t_identity_zero();
      drive16(16'd1, 16'hBEEF);
      check("R7 col16 a=1", pc16, 32'h0000BEEF);
      drive16(16'hC0DE, 16'd1);
      check("R7 row16 b=1", pr16, 32'h0000C0DE);
      drive16(16'd0, 16'hFFFF);
      check("R2 col16 a=0", pc16, 32'd0);
      drive16(16'hFFFF, 16'd0);
      check("R2 row16 b=0", pr16, 32'd0);
   endtask

   initial begin
      a4 = '0; b4 = '0; a16 = '0; b16 = '0;
      t_reset_state();
      t_doc_patterns();
      t_pending_carry();
      t_full_carry();
      t_identity_zero();
      t_exhaustive4();
      t_random16();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule